// File: doc/BRIEF.md
# Flow-through prefetch read buffer controller

This block manages the read data buffer of a bus bridge while it serves one prefetchable delayed read. A target-side engine writes words into a 16-entry circular buffer as it fetches them, and an address counter advances by one word for each word written. The initiator side takes words from the head of the buffer. The controller decides when the target engine has to stop fetching. It tells the initiator to disconnect with data when the buffer runs dry during streaming, and it drops leftover data that nobody comes back for.

A read normally completes in store-and-forward fashion: the target fills the buffer up to its own boundary, then the initiator drains it. If the initiator comes back and takes data while the target side is still fetching, the block switches to flow-through mode. In that mode words pass straight through the buffer and the fetch goes on until the first stop condition occurs. Leftover data is dropped when a countdown expires. It is dropped at once if another transaction has data waiting.

The controller has five named states. **IDLE** has no read. **PEND** means the read is posted and the initiator has not yet arrived. **STREAM** is flow-through draining. **DRAIN** is draining of data that the target has finished fetching. **WAIT** means the initiator has left and the countdown runs. The transitions are:
- start: IDLE→PEND.
- first take: PEND→STREAM or PEND→DRAIN.
- end or disconnect: STREAM→WAIT.
- complete: DRAIN→IDLE.
- leave: DRAIN→WAIT.
- resume: WAIT→STREAM or WAIT→DRAIN.
- discard: WAIT→IDLE.

Top module: `prefetch_stream_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_en_o`, `ini_avail_o`, `disc_o`, `flow_o` and `discard_o` are 0 and `tgt_addr_o` is 0.
- R2: `rd_start_i` in IDLE loads `rd_addr_i` into `tgt_addr_o` and raises `fetch_en_o` from the next cycle. Each word offered on `tgt_valid_i` while `fetch_en_o` is 1 is stored. Stored words appear on `ini_data_o` in arrival order, and `tgt_addr_o` grows by 4 for each stored word.
- R3: The first take in PEND (`ini_take_i` with `ini_avail_o` high) goes to STREAM (`flow_o`=1 from the next cycle) if fetching was enabled in that cycle. Otherwise it goes to DRAIN and `flow_o` stays 0.
- R4: `tgt_last_i` while fetching drops `fetch_en_o` from the next cycle.
- R5: When a word is stored and the following word address (current address + 4) has bits [11:0] equal to zero, `fetch_en_o` drops from the next cycle.
- R6: When the buffer holds 16 words, `fetch_en_o` drops and no further word is stored.
- R7: `ini_end_i` in STREAM stops fetching and enters WAIT in the next cycle.
- R8: In STREAM, `disc_o` is 1 whenever the buffer is empty and `ini_end_i` is 0. The next state is WAIT, and fetching goes on.
- R9: On entry to WAIT a countdown is loaded with TMO_CYCLES and decrements once per WAIT cycle. In the WAIT cycle where it reads zero, `discard_o` is 1, the buffer is emptied and the state returns to IDLE.
- R10: `other_pend_i` high in WAIT raises `discard_o` in the same cycle and empties the buffer without waiting for the countdown.
- R11: A discard takes precedence over a target word offered in the same cycle. In the discard cycle `ini_avail_o` is 0, and afterwards the buffer is empty and fetching is off.
- R12: DRAIN returns to IDLE once its last word is taken. After a completion or a discard, the next read starts with `flow_o`=0.
- R13: A take in WAIT resumes the read. It goes to STREAM if fetching is still enabled and to DRAIN otherwise, and the countdown is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_start_i | input | 1 | Post a new prefetchable read (used in IDLE only) |
| rd_addr_i | input | ADDR_W | Start address of the read |
| tgt_valid_i | input | 1 | Target side offers a word |
| tgt_data_i | input | DATA_W | Word from the target side |
| tgt_last_i | input | 1 | Target read reached its own boundary or ended |
| fetch_en_o | output | 1 | Target side may fetch and write a word |
| tgt_addr_o | output | ADDR_W | Address of the next target word |
| ini_take_i | input | 1 | Initiator takes the head word |
| ini_end_i | input | 1 | Initiator terminates its transfer |
| ini_avail_o | output | 1 | A word is available to the initiator |
| ini_data_o | output | DATA_W | Head word of the buffer |
| disc_o | output | 1 | Disconnect-with-data indication |
| flow_o | output | 1 | Flow-through mode active |
| other_pend_i | input | 1 | Another transaction has data pending |
| discard_o | output | 1 | Leftover read data dropped this cycle |

## Verification
Every output of this block is a function of the registered state and the inputs of the current cycle, so each result is due in the cycle after the clock edge that consumes its stimulus. The discard is the exception: it comes TMO_CYCLES+1 WAIT cycles after entry, or in the same cycle that `other_pend_i` rises. The bench drives inputs half a nanosecond after each falling edge and compares every output with a behavioural queue model one nanosecond after that falling edge. That sample point falls between the input change and the next rising edge. Directed checks read the ports after the rising edge that applies a stimulus, with the inputs already returned to zero.

// File: rtl/pfs_pkg.sv
`timescale 1ns/100ps
package pfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_STREAM,
        ST_DRAIN,
        ST_WAIT
    } pfs_state_e;
endpackage

// File: rtl/pfs_fifo.sv
`timescale 1ns/100ps
module pfs_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [WIDTH-1:0]             wr_data,
    input  logic                         rd_en,
    input  logic                         flush,
    output logic [WIDTH-1:0]             rd_data,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
        end
    end

    assign rd_data = mem[rd_ptr];
    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty); // R2
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R11
endmodule

// File: rtl/pfs_addr.sv
`timescale 1ns/100ps
module pfs_addr #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int PAGE_BITS  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_o,
    output logic              page_end_o
);
    logic [ADDR_W-1:0] addr_nxt;

    assign addr_nxt   = addr_o + ADDR_W'(WORD_BYTES);
    assign page_end_o = (addr_nxt[PAGE_BITS-1:0] == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (load) begin
            addr_o <= load_addr;
        end else if (step) begin
            addr_o <= addr_nxt;
        end
    end
endmodule

// File: rtl/pfs_timer.sv
`timescale 1ns/100ps
module pfs_timer #(
    parameter int LIMIT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero_o
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= TW'(LIMIT);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/prefetch_stream_ctrl.sv
`timescale 1ns/100ps
module prefetch_stream_ctrl
    import pfs_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int DEPTH      = 16,
    parameter int TMO_CYCLES = 32768,
    parameter int WORD_BYTES = 4,
    parameter int PAGE_BITS  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              tgt_valid_i,
    input  logic [DATA_W-1:0] tgt_data_i,
    input  logic              tgt_last_i,
    output logic              fetch_en_o,
    output logic [ADDR_W-1:0] tgt_addr_o,
    input  logic              ini_take_i,
    input  logic              ini_end_i,
    output logic              ini_avail_o,
    output logic [DATA_W-1:0] ini_data_o,
    output logic              disc_o,
    output logic              flow_o,
    input  logic              other_pend_i,
    output logic              discard_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    pfs_state_e         state_q, state_d;
    logic               fetching_q;
    logic               full, empty, page_end, tmo_zero;
    logic               flush, wr, pop, start;
    logic [CNT_W-1:0]   count;
    logic [CNT_W:0]     cnt_after;

    pfs_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr), .wr_data(tgt_data_i),
        .rd_en(pop), .flush(flush), .rd_data(ini_data_o),
        .full(full), .empty(empty), .count(count)
    );

    pfs_addr #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .PAGE_BITS(PAGE_BITS)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(start), .load_addr(rd_addr_i),
        .step(wr), .addr_o(tgt_addr_o), .page_end_o(page_end)
    );

    pfs_timer #(.LIMIT(TMO_CYCLES)) u_tmo (
        .clk(clk), .rst_n(rst_n),
        .load(state_d == ST_WAIT && state_q != ST_WAIT),
        .run(state_q == ST_WAIT), .zero_o(tmo_zero)
    );

    // Output and handshake decode
    always_comb begin
        start       = (state_q == ST_IDLE) && rd_start_i;
        flush       = (state_q == ST_WAIT) && (other_pend_i || tmo_zero);
        fetch_en_o  = fetching_q && !full;
        wr          = fetch_en_o && tgt_valid_i && !flush;
        ini_avail_o = !empty && !flush && (state_q != ST_IDLE);
        pop         = ini_take_i && ini_avail_o;
        disc_o      = (state_q == ST_STREAM) && empty && !ini_end_i;
        flow_o      = (state_q == ST_STREAM);
        discard_o   = flush;
        cnt_after   = {1'b0, count} + {{CNT_W{1'b0}}, wr} - {{CNT_W{1'b0}}, pop};
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (rd_start_i) state_d = ST_PEND;
            ST_PEND:   if (pop) state_d = fetching_q ? ST_STREAM : ST_DRAIN;
            ST_STREAM: if (ini_end_i || empty) state_d = ST_WAIT;
            ST_DRAIN: begin
                if (cnt_after == '0)  state_d = ST_IDLE;
                else if (ini_end_i)   state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (flush)     state_d = ST_IDLE;
                else if (pop)  state_d = fetching_q ? ST_STREAM : ST_DRAIN;
            end
            default:           state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Target fetch permission
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            fetching_q <= 1'b0;
        end else if (start) begin
            fetching_q <= 1'b1;
        end else if (fetching_q && (tgt_last_i || (wr && page_end) ||
                     cnt_after == (CNT_W+1)'(DEPTH) ||
                     (state_q == ST_STREAM && ini_end_i))) begin
            fetching_q <= 1'b0;
        end
    end

    AST_LAST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching_q && tgt_last_i) |=> !fetch_en_o); // R4
    AST_PAGE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && page_end) |=> !fetch_en_o); // R5
    AST_END_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM && ini_end_i) |=> (!fetch_en_o && state_q == ST_WAIT)); // R7
    AST_FLOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && pop && fetching_q) |=> flow_o); // R3
    AST_DISC_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        disc_o |=> (state_q == ST_WAIT)); // R8
    AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && other_pend_i) |=> (state_q == ST_IDLE && empty)); // R10
endmodule

// File: tb/test_prefetch_stream_ctrl.sv
`timescale 1ns/100ps
module test_prefetch_stream_ctrl;
    localparam int DEPTH = 16;
    localparam int TMO   = 8;
    localparam int M_IDLE = 0, M_PEND = 1, M_STREAM = 2, M_DRAIN = 3, M_WAIT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_start = 0, tgt_valid = 0, tgt_last = 0, ini_take = 0, ini_end = 0, other_pend = 0;
    logic [31:0] rd_addr = 0, tgt_data = 0;
    logic fetch_en, ini_avail, disc, flow, discard;
    logic [31:0] tgt_addr, ini_data;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prefetch_stream_ctrl #(.TMO_CYCLES(TMO)) i_prefetch_stream_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_start_i(rd_start), .rd_addr_i(rd_addr),
        .tgt_valid_i(tgt_valid), .tgt_data_i(tgt_data), .tgt_last_i(tgt_last),
        .fetch_en_o(fetch_en), .tgt_addr_o(tgt_addr), .ini_take_i(ini_take),
        .ini_end_i(ini_end), .ini_avail_o(ini_avail), .ini_data_o(ini_data),
        .disc_o(disc), .flow_o(flow), .other_pend_i(other_pend), .discard_o(discard)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int          m_st = M_IDLE;
    logic [31:0] q[$];
    bit          m_fetch = 0;
    logic [31:0] m_addr = 0;
    int          m_tmr = 0;
    int          sz, after, nst;
    bit          fl, w, p, nf;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_IDLE; q.delete(); m_fetch = 0; m_addr = 0; m_tmr = 0;
        end else begin
            sz    = q.size();
            fl    = (m_st == M_WAIT) && (other_pend || m_tmr == 0);
            w     = m_fetch && sz < DEPTH && tgt_valid && !fl;
            p     = ini_take && sz > 0 && !fl && m_st != M_IDLE;
            after = sz + int'(w) - int'(p);
            nst   = m_st;
            case (m_st)
                M_IDLE:   if (rd_start) nst = M_PEND;
                M_PEND:   if (p) nst = m_fetch ? M_STREAM : M_DRAIN;
                M_STREAM: if (ini_end || sz == 0) nst = M_WAIT;
                M_DRAIN:  if (after == 0) nst = M_IDLE; else if (ini_end) nst = M_WAIT;
                default:  if (fl) nst = M_IDLE; else if (p) nst = m_fetch ? M_STREAM : M_DRAIN;
            endcase
            nf = m_fetch;
            if (fl) nf = 0;
            else if (m_st == M_IDLE && rd_start) nf = 1;
            else if (m_fetch && (tgt_last || (w && ((m_addr + 4) & 32'hFFF) == 0) ||
                     after == DEPTH || (m_st == M_STREAM && ini_end))) nf = 0;
            if (m_st == M_IDLE && rd_start) m_addr = rd_addr;
            else if (w) m_addr = m_addr + 4;
            if (nst == M_WAIT && m_st != M_WAIT) m_tmr = TMO;
            else if (m_st == M_WAIT && m_tmr != 0) m_tmr = m_tmr - 1;
            if (fl) q.delete();
            else begin
                if (p) void'(q.pop_front());
                if (w) q.push_back(tgt_data);
            end
            m_st = nst;
            m_fetch = nf;
        end
    end

    // Per-cycle comparison, between input change and the next rising edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(32'(fetch_en), 32'(m_fetch && q.size() < DEPTH), "R6 fetch_en vs model");
            chk(32'(ini_avail), 32'(q.size() > 0 && m_st != M_IDLE &&
                !(m_st == M_WAIT && (other_pend || m_tmr == 0))), "R11 ini_avail vs model");
            if (ini_avail && q.size() > 0) chk(ini_data, q[0], "R2 ini_data vs model");
            chk(32'(disc), 32'(m_st == M_STREAM && q.size() == 0 && !ini_end), "R8 disc vs model");
            chk(32'(flow), 32'(m_st == M_STREAM), "R3 flow vs model");
            chk(32'(discard), 32'(m_st == M_WAIT && (other_pend || m_tmr == 0)), "R9 discard vs model");
            chk(tgt_addr, m_addr, "R2 tgt_addr vs model");
        end
    end

    task automatic cyc(input bit st = 0, input bit tv = 0, input logic [31:0] td = 0,
                       input bit tl = 0, input bit tk = 0, input bit ie = 0, input bit op = 0);
        rd_start = st; tgt_valid = tv; tgt_data = td; tgt_last = tl;
        ini_take = tk; ini_end = ie; other_pend = op;
        @(negedge clk);
        rd_start = 0; tgt_valid = 0; tgt_last = 0; ini_take = 0; ini_end = 0; other_pend = 0;
        #0.5;
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        #0.5;
        chk(32'({fetch_en, ini_avail, disc, flow, discard}), 0, "R1 outputs in reset");
        @(negedge clk); rst_n = 1'b1; #0.5;
        chk(32'({fetch_en, ini_avail, disc, flow, discard}), 0, "R1 outputs after reset");
        chk(tgt_addr, 0, "R1 address after reset");

        // Store-and-forward read, plain drain
        rd_addr = 32'h100; cyc(.st(1));
        chk(32'(fetch_en), 1, "R2 fetch enabled after start");
        chk(tgt_addr, 32'h100, "R2 address loaded");
        cyc(.tv(1), .td(32'hA0)); cyc(.tv(1), .td(32'hA1)); cyc(.tv(1), .td(32'hA2));
        cyc(.tv(1), .td(32'hA3), .tl(1));
        chk(32'(fetch_en), 0, "R4 stop on target last");
        chk(tgt_addr, 32'h110, "R2 address advanced by 4 per word");
        chk(ini_data, 32'hA0, "R2 first word in order");
        cyc(.tk(1));
        chk(32'(flow), 0, "R3 take after fetch end gives DRAIN");
        chk(ini_data, 32'hA1, "R2 second word in order");
        cyc(.tk(1)); cyc(.tk(1)); cyc(.tk(1));
        chk(32'(ini_avail), 0, "R12 drain complete back to idle");

        // Flow-through, disconnect, resume, end, timeout
        rd_addr = 32'h2000; cyc(.st(1));
        cyc(.tv(1), .td(32'hD0)); cyc(.tv(1), .td(32'hD1));
        cyc(.tv(1), .td(32'hD2), .tk(1));
        chk(32'(flow), 1, "R3 take while fetching enters STREAM");
        cyc(.tk(1)); cyc(.tk(1));
        chk(32'(disc), 1, "R8 disconnect on empty buffer");
        cyc(.tv(1), .td(32'hD3));
        chk(32'(disc), 0, "R8 disconnect leaves STREAM");
        chk(32'(fetch_en), 1, "R8 target keeps fetching after disconnect");
        cyc(.tv(1), .td(32'hD4), .tk(1));
        chk(32'(flow), 1, "R13 resume while fetching re-enters STREAM");
        cyc(.tv(1), .td(32'hD5), .ie(1));
        chk(32'(fetch_en), 0, "R7 initiator end stops fetch");
        chk(32'(flow), 0, "R7 initiator end enters WAIT");
        for (int i = 0; i < TMO; i++) begin
            chk(32'(ini_avail), 1, "R9 leftover kept before countdown ends");
            cyc();
        end
        chk(32'(discard), 1, "R9 discard when countdown reaches zero");
        cyc();
        chk(32'(ini_avail), 0, "R9 leftover dropped");

        // Page boundary stop
        rd_addr = 32'hFF8; cyc(.st(1));
        cyc(.tv(1), .td(32'hE0));
        chk(32'(fetch_en), 1, "R5 no stop before boundary");
        cyc(.tv(1), .td(32'hE1));
        chk(32'(fetch_en), 0, "R5 stop at 4 KB boundary");
        chk(tgt_addr, 32'h1000, "R5 address at boundary");
        cyc(.tk(1)); cyc(.tk(1));
        chk(32'(ini_avail), 0, "R12 boundary read completes");

        // Full buffer, resume into DRAIN, pending-data discard
        rd_addr = 32'h0; cyc(.st(1));
        for (int i = 0; i < DEPTH; i++) begin
            chk(32'(fetch_en), 1, "R6 fetch enabled below full");
            cyc(.tv(1), .td(32'h300 + 32'(i)));
        end
        chk(32'(fetch_en), 0, "R6 stop when buffer full");
        cyc(.tv(1), .td(32'hBAD));
        chk(tgt_addr, 32'h40, "R6 no word stored while full");
        cyc(.tk(1)); cyc(.tk(1)); cyc(.tk(1));
        cyc(.ie(1));
        chk(32'(ini_avail), 1, "R10 leftover held in WAIT");
        cyc(.tk(1));
        chk(32'(flow), 0, "R13 resume without fetch gives DRAIN");
        cyc(.ie(1));
        cyc(.op(1));
        chk(32'(ini_avail), 0, "R10 pending data drops leftover at once");

        // Discard beats a simultaneous target word
        rd_addr = 32'h40; cyc(.st(1));
        cyc(.tv(1), .td(32'hF0));
        cyc(.tv(1), .td(32'hF1), .tk(1));
        cyc(.tk(1));
        cyc();
        chk(32'(fetch_en), 1, "R11 fetching before discard");
        cyc(.tv(1), .td(32'hF2), .op(1));
        chk(32'(ini_avail), 0, "R11 buffer empty after discard");
        chk(32'(fetch_en), 0, "R11 fetching off after discard");
        cyc();
        chk(32'(ini_avail), 0, "R11 word offered during discard not stored");

        // New read after discard starts non-flow
        rd_addr = 32'h80; cyc(.st(1));
        chk(32'(flow), 0, "R12 new read starts non-flow");
        cyc(.tv(1), .td(32'h11)); cyc(.tv(1), .td(32'h12), .tl(1));
        cyc(.tk(1));
        chk(32'(flow), 0, "R12 drain without flow-through");
        cyc(.tk(1));
        chk(32'(ini_avail), 0, "R12 second read completes");
        cyc();
        finish_run();
    end
endmodule